// File: doc/BRIEF.md
# Daisy-Chained Serial Receive Word Selector

This block is the receive side of a 16-bit synchronous serial port built for a chain of identical converter devices on one serial bus. The host drives a frame sync and a bit stream into the first device. Each device passes the stream on through a 16-bit shift register to the next device, and it regenerates a frame sync at the end of each complete word. The system clock is the serial clock, so one bit moves on each rising edge.

Each device knows the chain length from a 3-bit field that holds the number of devices minus one. After each sample-period strobe the device counts incoming frame syncs. When the word opened by sync number (field + 1) is complete, the word now in the shift register belongs to this device. The device copies it into its parallel output register and raises a one-cycle valid pulse. It then ignores further frame syncs until the next strobe. A frame sync that arrives before a word is complete throws that partial word away and starts a new one.

Top module: `casc_rx`

## Requirements
- R1: After reset, `dacWord`, `dacValid`, `fsOut` and `sdOut` are all 0. The stored device-count field is 0, which means one device.
- R2: A word is 16 bits long and arrives most significant bit first. The bit on `sdIn` in the clock period in which `fsIn` is high is bit 15.
- R3: In every clock period, `sdOut` equals the value `sdIn` had 16 clock periods earlier. It is 0 until that history exists after reset.
- R4: `fsOut` is high for exactly one period. It rises 15 rising edges after the edge that sampled the `fsIn` of a word, provided all 16 bits of that word arrived with no new `fsIn`. In that period `sdOut` carries the word's bit 15.
- R5: A rising edge with `cfgLoad` high stores `cfgCount` as the device-count field. The field holds the number of devices minus one (0 = 1 device, 7 = 8 devices). `cfgCount` has no effect while `cfgLoad` is low.
- R6: The frame sync opened by edge number (field + 1) after a strobe marks the selected word. When its 16th bit is sampled, `dacWord` takes that word and `dacValid` is high for the following period. This period is the same one in which that word's `fsOut` is high.
- R7: After a capture, further frame syncs are not counted and no capture occurs until `samplePulse` is seen again.
- R8: An `fsIn` during an unfinished word drops the partial word. That word produces no `fsOut` and no capture, though its sync still counted. The new sync starts a new word.
- R9: `dacValid` never stays high for two periods in a row. `dacWord` changes only together with `dacValid` and holds otherwise.
- R10: `samplePulse` clears the sync count. An `fsIn` in the same period as `samplePulse` counts as the first sync of the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; one bit per rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Store `cfgCount` as the device-count field |
| cfgCount | input | 3 | Number of chained devices minus one |
| samplePulse | input | 1 | Sample-period strobe; clears the sync count |
| fsIn | input | 1 | Frame sync, high with bit 15 of a word |
| sdIn | input | 1 | Serial data in |
| fsOut | output | 1 | Regenerated frame sync for the next device |
| sdOut | output | 1 | Serial data out, 16 periods behind `sdIn` |
| dacWord | output | 16 | Parallel output word |
| dacValid | output | 1 | One-period pulse when `dacWord` is updated |

## Verification
On every cycle the checker confirms the 16-period data delay from `sdIn` to `sdOut`. It also checks that `fsOut` and `dacValid` are single-period pulses, and that a capture only comes together with a regenerated sync. It checks that `dacWord` never moves without `dacValid` and that at most one capture happens per strobe. Only the bench scenarios can show the rest. That covers which word in a frame is picked for each chain length, the exact capture period measured from that word's sync, and the effect of a partial word on the count. It also covers a strobe that coincides with a sync and the reset-default field of one device.

// File: rtl/casc_rx_pkg.sv
package casc_rx_pkg;

  // Per-cycle strobes from the sequencer to the datapath
  typedef struct packed {
    logic wordDone;   // 16th bit of an uninterrupted word sampled this edge
    logic capture;    // that word is this device's own word
  } seqStrobe_t;

endpackage

// File: rtl/casc_rx_seq.sv
module casc_rx_seq
  import casc_rx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             samplePulse,
  input  logic             fsIn,
  output seqStrobe_t       strobes
);

  localparam int BIT_W = $clog2(WORD_W);
  localparam int FS_W  = CNT_W + 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [FS_W-1:0]  FS_MAX   = '1;

  logic [CNT_W-1:0] devCountQ;
  logic [BIT_W-1:0] bitCnt;
  logic             active;
  logic [FS_W-1:0]  fsCnt;
  logic             doneQ;
  logic [FS_W-1:0]  target;
  logic             wordDone;
  logic             capture;

  // Stored chain length (devices minus one)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devCountQ <= '0;
    end else if (cfgLoad) begin
      devCountQ <= cfgCount;
    end
  end

  // Bit position inside the current word; a sync always restarts it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (fsIn) begin
      active <= 1'b1;
      bitCnt <= BIT_W'(1);
    end else if (active) begin
      if (bitCnt == LAST_BIT) begin
        active <= 1'b0;
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + BIT_W'(1);
      end
    end
  end

  assign wordDone = active && !fsIn && (bitCnt == LAST_BIT);
  assign target   = FS_W'(devCountQ) + FS_W'(1);
  assign capture  = wordDone && !doneQ && (fsCnt == target);

  // Sync counter per sample period, frozen once the own word was taken
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsCnt <= '0;
      doneQ <= 1'b0;
    end else if (samplePulse) begin
      fsCnt <= fsIn ? FS_W'(1) : '0;
      doneQ <= 1'b0;
    end else begin
      if (fsIn && !doneQ && (fsCnt != FS_MAX)) begin
        fsCnt <= fsCnt + FS_W'(1);
      end
      if (capture) begin
        doneQ <= 1'b1;
      end
    end
  end

  assign strobes.wordDone = wordDone;
  assign strobes.capture  = capture;

endmodule

// File: rtl/casc_rx_dp.sv
module casc_rx_dp
  import casc_rx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdIn,
  input  seqStrobe_t        strobes,
  output logic              sdOut,
  output logic              fsOut,
  output logic [WORD_W-1:0] dacWord,
  output logic              dacValid
);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextShift;

  assign nextShift = {shiftReg[WORD_W-2:0], sdIn};

  // Free-running chain register: the oldest bit leaves on sdOut
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else begin
      shiftReg <= nextShift;
    end
  end

  assign sdOut = shiftReg[WORD_W-1];

  // Regenerated sync lines up with the MSB of the word now leaving
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsOut <= 1'b0;
    end else begin
      fsOut <= strobes.wordDone;
    end
  end

  // Parallel output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacWord  <= '0;
      dacValid <= 1'b0;
    end else begin
      dacValid <= strobes.capture;
      if (strobes.capture) begin
        dacWord <= nextShift;
      end
    end
  end

endmodule

// File: rtl/casc_rx.sv
module casc_rx
  import casc_rx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              samplePulse,
  input  logic              fsIn,
  input  logic              sdIn,
  output logic              fsOut,
  output logic              sdOut,
  output logic [WORD_W-1:0] dacWord,
  output logic              dacValid
);

  seqStrobe_t strobes;

  casc_rx_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgCount(cfgCount),
    .samplePulse(samplePulse), .fsIn(fsIn), .strobes(strobes)
  );

  casc_rx_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .sdIn(sdIn), .strobes(strobes),
    .sdOut(sdOut), .fsOut(fsOut), .dacWord(dacWord), .dacValid(dacValid)
  );

endmodule

// File: rtl/casc_rx_chk.sv
module casc_rx_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              samplePulse,
  input logic              sdIn,
  input logic              sdOut,
  input logic              fsOut,
  input logic [WORD_W-1:0] dacWord,
  input logic              dacValid
);

  logic [WORD_W-1:0] histQ;
  logic              strobeQ;
  logic              takenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histQ   <= '0;
      strobeQ <= 1'b0;
      takenQ  <= 1'b0;
    end else begin
      histQ   <= {histQ[WORD_W-2:0], sdIn};
      strobeQ <= samplePulse;
      if (samplePulse) takenQ <= 1'b0;
      else if (dacValid && !strobeQ) takenQ <= 1'b1;
    end
  end

  // R3
  sd_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdOut == histQ[WORD_W-1]);

  // R4
  fs_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fsOut |=> !fsOut);

  // R6
  capture_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    dacValid |-> fsOut);

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dacValid |=> !dacValid);

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacWord) |-> dacValid);

  // R7
  one_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    dacValid |-> !takenQ);

endmodule

bind casc_rx casc_rx_chk #(.WORD_W(WORD_W)) u_casc_rx_chk (
  .clk(clk), .rstN(rstN), .samplePulse(samplePulse), .sdIn(sdIn),
  .sdOut(sdOut), .fsOut(fsOut), .dacWord(dacWord), .dacValid(dacValid)
);

// File: tb/test_casc_rx.sv
module test_casc_rx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [2:0]  cfgCount = 3'd0;
  logic        samplePulse = 1'b0;
  logic        fsIn = 1'b0;
  logic        sdIn = 1'b0;
  logic        fsOut;
  logic        sdOut;
  logic [15:0] dacWord;
  logic        dacValid;

  casc_rx i_casc_rx (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgCount(cfgCount),
    .samplePulse(samplePulse), .fsIn(fsIn), .sdIn(sdIn),
    .fsOut(fsOut), .sdOut(sdOut), .dacWord(dacWord), .dacValid(dacValid)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int validCount = 0, lastValidCyc = -1;
  int fsCount = 0, lastFsCyc = -1;
  logic [15:0] lastDac = '0;
  logic [15:0] sdHist = '0;
  int syncCyc [16];

  // Vector: {field, words in frame, expected word index (15 = none)}
  localparam logic [10:0] VEC [8] = '{
    {3'd0, 4'd1, 4'd0}, {3'd0, 4'd3, 4'd0}, {3'd1, 4'd2, 4'd1},
    {3'd2, 4'd5, 4'd2}, {3'd3, 4'd3, 4'hF}, {3'd7, 4'd8, 4'd7},
    {3'd6, 4'd6, 4'hF}, {3'd4, 4'd6, 4'd4}
  };

  function automatic logic [15:0] wordOf(int v, int k);
    return 16'(16'h5A3C ^ (v * 16'h0137) ^ (k * 16'h1F01) ^ (k << 13));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) sdHist <= '0;
    else sdHist <= {sdHist[14:0], sdIn};
  end

  // Output monitor, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(sdOut == sdHist[15], "R3", "sdOut delay", sdOut, sdHist[15]);
      if (dacValid) begin
        validCount++;
        lastValidCyc = cyc;
        lastDac = dacWord;
      end
      if (fsOut) begin
        fsCount++;
        lastFsCyc = cyc;
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fsIn = 1'b0; sdIn = 1'b0; samplePulse = 1'b0; cfgLoad = 1'b0;
    end
  endtask

  task automatic loadCfg(logic [2:0] v);
    @(negedge clk);
    cfgLoad = 1'b1; cfgCount = v; fsIn = 1'b0; samplePulse = 1'b0;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    samplePulse = 1'b1; fsIn = 1'b0; sdIn = 1'b0;
  endtask

  // Sends nbits of a word MSB first; returns the edge that samples its sync
  task automatic sendWord(logic [15:0] w, int nbits, bit withStrobe, output int sc);
    sc = 0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      fsIn = (i == 0);
      sdIn = w[15 - i];
      samplePulse = (i == 0) && withStrobe;
      cfgLoad = 1'b0;
      if (i == 0) sc = cyc + 1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R6 watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int sc, vc0, fc0;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(dacWord == 16'h0, "R1", "dacWord after reset", dacWord, 0);
    chk(dacValid == 1'b0, "R1", "dacValid after reset", dacValid, 0);
    chk(fsOut == 1'b0, "R1", "fsOut after reset", fsOut, 0);
    chk(sdOut == 1'b0, "R1", "sdOut after reset", sdOut, 0);

    // R1/R5: default field is one device; cfgCount without cfgLoad is ignored
    cfgCount = 3'd5;
    strobe();
    vc0 = validCount;
    sendWord(16'hC3A5, 16, 1'b0, sc);
    idle(3);
    chk(validCount - vc0 == 1, "R5", "default single-device capture count", validCount - vc0, 1);
    chk(lastDac == 16'hC3A5, "R2", "MSB-first word", lastDac, 16'hC3A5);
    chk(lastValidCyc == sc + 15, "R6", "capture period", lastValidCyc, sc + 15);
    chk(lastFsCyc == sc + 15, "R4", "fsOut period", lastFsCyc, sc + 15);

    // Table walk: R5/R6/R7/R4 across chain lengths
    for (int v = 0; v < 8; v++) begin
      logic [2:0] fld;
      int nw, ex;
      fld = VEC[v][10:8];
      nw  = int'(VEC[v][7:4]);
      ex  = int'(VEC[v][3:0]);
      loadCfg(fld);
      strobe();
      vc0 = validCount; fc0 = fsCount; held = dacWord;
      for (int k = 0; k < nw; k++) begin
        sendWord(wordOf(v, k), 16, 1'b0, sc);
        syncCyc[k] = sc;
      end
      idle(3);
      chk(fsCount - fc0 == nw, "R4", "fsOut pulses per frame", fsCount - fc0, nw);
      chk(lastFsCyc == syncCyc[nw - 1] + 15, "R4", "last fsOut period", lastFsCyc, syncCyc[nw - 1] + 15);
      if (ex == 15) begin
        chk(validCount == vc0, "R6", "no capture for short frame", validCount - vc0, 0);
        chk(dacWord == held, "R9", "word held", dacWord, held);
      end else begin
        chk(validCount - vc0 == 1, "R7", "one capture per frame", validCount - vc0, 1);
        chk(lastDac == wordOf(v, ex), "R6", "selected word", lastDac, wordOf(v, ex));
        chk(lastValidCyc == syncCyc[ex] + 15, "R6", "selected capture period", lastValidCyc, syncCyc[ex] + 15);
      end
    end

    // R7/R9: no strobe, more words -> nothing changes
    loadCfg(3'd0);
    vc0 = validCount; held = dacWord;
    for (int k = 0; k < 3; k++) sendWord(wordOf(20, k), 16, 1'b0, sc);
    idle(3);
    chk(validCount == vc0, "R7", "syncs ignored after capture", validCount - vc0, 0);
    chk(dacWord == held, "R9", "dacWord holds", dacWord, held);

    // R10: strobe together with the first sync
    sendWord(16'h1234, 16, 1'b1, sc);
    idle(3);
    chk(validCount - vc0 == 1, "R10", "strobe with sync counts it", validCount - vc0, 1);
    chk(lastDac == 16'h1234, "R10", "captured word", lastDac, 16'h1234);

    // R10: strobe between words restarts the count
    loadCfg(3'd1);
    strobe();
    vc0 = validCount;
    sendWord(16'hAAAA, 16, 1'b0, sc);
    strobe();
    sendWord(16'hBBBB, 16, 1'b0, sc);
    sendWord(16'hCCCC, 16, 1'b0, sc);
    idle(3);
    chk(validCount - vc0 == 1, "R10", "count restarted by strobe", validCount - vc0, 1);
    chk(lastDac == 16'hCCCC, "R10", "second word after strobe", lastDac, 16'hCCCC);

    // R8: partial word counted but dropped (field 1 -> full word after it is taken)
    strobe();
    vc0 = validCount; fc0 = fsCount;
    sendWord(16'hF0F0, 7, 1'b0, sc);
    sendWord(16'h0F5A, 16, 1'b0, sc);
    idle(3);
    chk(fsCount - fc0 == 1, "R8", "no fsOut for partial word", fsCount - fc0, 1);
    chk(validCount - vc0 == 1, "R8", "capture after partial", validCount - vc0, 1);
    chk(lastDac == 16'h0F5A, "R8", "full word captured", lastDac, 16'h0F5A);
    chk(lastValidCyc == sc + 15, "R8", "capture period after restart", lastValidCyc, sc + 15);

    // R8: field 0 -> the partial word was the selected one, nothing captured
    loadCfg(3'd0);
    strobe();
    vc0 = validCount; held = dacWord;
    sendWord(16'h7777, 9, 1'b0, sc);
    sendWord(16'h9999, 16, 1'b0, sc);
    idle(3);
    chk(validCount == vc0, "R8", "dropped word not captured", validCount - vc0, 0);
    chk(dacWord == held, "R8", "dacWord unchanged", dacWord, held);

    idle(20);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule